// File: doc/BRIEF.md
# Trap and Interrupt Control Unit

This unit sits beside the pipeline of a small processor and decides, for every instruction slot, whether execution continues or is diverted into a trap. It keeps a cause register in which the low byte holds the code of the last trap and the next byte holds eight interrupt-pending flags. It also keeps a status register with a trap-enable bit, a supervisor bit, a previous-supervisor bit and an eight-bit interrupt mask. A counter advances with each completed instruction, and when it meets a compare value it raises the top pending flag as a timer interrupt.

Each slot is marked by a `slotValid` strobe together with the current PC and an optional synchronous exception request and its code. The interrupt check comes first. If any pending flag is unmasked while traps are enabled, an interrupt trap is taken. Otherwise a requested exception traps with its own code. Otherwise the instruction completes and the counter advances. On a trap the unit saves the PC, updates status and the cause code, and in the following cycle pulses `redirect` with the handler address held in its vector register. Software can write status, count, compare, cause and the vector through a simple write port.

Top module: `trap_irq_unit`

## Requirements
- R1: After reset, count, compare, cause, exception PC and vector are zero, `redirect` is low, and status reads 0x2 (supervisor set, trap-enable and previous-supervisor clear, mask zero).
- R2: Each slot that does not trap adds one to count. A cycle without a slot leaves count unchanged. A write to count (address 1) loads it.
- R3: A slot that completes while count, before its increment, equals compare sets the timer pending flag (cause bit 15). The flag is visible in the cycle after that slot.
- R4: A write to compare (address 2) loads the new compare value and clears cause bit 15. The clear takes priority over a match in the same cycle.
- R5: Interrupt lines 0 to 6 are registered every cycle into cause bits 8 to 14, one cycle after they are driven. Software writes to cause do not alter those bits, and cause bits 31:16 always read zero.
- R6: In a slot where (cause[15:8] AND status[15:8]) is nonzero and status bit 0 (trap-enable) is set, an interrupt trap is taken. It writes the code given by INT_CODE (default 6) into cause bits 7:0, and count does not advance.
- R7: When the unmasked pending set is empty or trap-enable is clear, the slot completes normally: there is no redirect and count advances.
- R8: A slot with `excReq` high and no interrupt taken traps with `excCode` written into cause bits 7:0, regardless of trap-enable.
- R9: When an interrupt and a synchronous exception fall in the same slot, the interrupt wins and its code is recorded.
- R10: On any trap, status bit 0 (trap-enable) clears, bit 1 (supervisor) sets, bit 2 (previous supervisor) takes the old bit 1, and the mask in bits 15:8 is kept.
- R11: A trap overwrites only cause bits 7:0. The pending byte, including the timer flag, is preserved.
- R12: On a trap, the exception PC takes the slot's PC, `redirect` is high for exactly the next cycle, and `trapTarget` shows the vector register (address 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| slotValid | input | 1 | An instruction slot is presented this cycle |
| pcIn | input | 32 | PC of the slot |
| excReq | input | 1 | Synchronous exception request for the slot |
| excCode | input | 8 | Code of the requested exception |
| irqLines | input | 7 | External interrupt request lines 0 to 6 |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select: 0 status, 1 count, 2 compare, 3 cause, 4 vector |
| regWrData | input | 32 | Register write data |
| redirect | output | 1 | One-cycle pulse after a trap is taken |
| trapTarget | output | 32 | Handler address (vector register) |
| epcOut | output | 32 | Saved exception PC |
| causeOut | output | 32 | Cause register |
| statusOut | output | 32 | Status register |

## Verification
The bench builds the unit with its defaults: a 32-bit word, an 8-bit code field, eight pending flags with the timer on flag 7, and an interrupt code of 6. Because compare is a small loadable value, a timer match can be reached within a handful of slots, and the reload and clear can be checked on the very next match. With the interrupt code fixed at 6, distinct from the synchronous code used alongside it, the bench can tell from cause alone which source won a contested slot.

// File: rtl/tcu_pkg.sv
package tcu_pkg;
  localparam int CODE_W   = 8;
  localparam int IRQ_N    = 8;
  localparam int ADDR_W   = 3;

  localparam logic [ADDR_W-1:0] ADDR_STATUS  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_COUNT   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_COMPARE = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CAUSE   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_VECTOR  = 3'd4;

  // status bit positions
  localparam int ST_ET   = 0;
  localparam int ST_SUP  = 1;
  localparam int ST_PSUP = 2;
  localparam int ST_MASK = 8;
  // cause field positions
  localparam int CA_PEND = 8;

  typedef struct packed {
    logic              takeTrap;
    logic [CODE_W-1:0] trapCode;
    logic              countInc;
    logic              timerSet;
    logic              wrStatus;
    logic              wrCount;
    logic              wrCompare;
    logic              wrCause;
    logic              wrVector;
  } tcuStrobes_t;
endpackage

// File: rtl/tcu_ctrl.sv
module tcu_ctrl
  import tcu_pkg::*;
#(
  parameter logic [CODE_W-1:0] INT_CODE = 8'd6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotValid,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              intrReady,
  input  logic              trapsEnabled,
  input  logic              countMatch,
  output tcuStrobes_t       str
);
  logic intrTake;
  logic excTake;

  always_comb begin
    intrTake     = slotValid && trapsEnabled && intrReady;
    excTake      = slotValid && excReq && !intrTake;
    str          = '0;
    str.takeTrap = intrTake || excTake;
    str.trapCode = intrTake ? INT_CODE : excCode;
    str.countInc = slotValid && !str.takeTrap;
    str.timerSet = str.countInc && countMatch;
    str.wrStatus  = regWrEn && (regAddr == ADDR_STATUS);
    str.wrCount   = regWrEn && (regAddr == ADDR_COUNT);
    str.wrCompare = regWrEn && (regAddr == ADDR_COMPARE);
    str.wrCause   = regWrEn && (regAddr == ADDR_CAUSE);
    str.wrVector  = regWrEn && (regAddr == ADDR_VECTOR);
  end

  // R8: a trap only ever comes from a presented slot
  a_r8_trap_needs_slot: assert property (@(posedge clk) disable iff (!rstN)
    str.takeTrap |-> slotValid)
    else $error("trap without slot");

endmodule

// File: rtl/tcu_dp.sv
module tcu_dp
  import tcu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  tcuStrobes_t       str,
  input  logic [XLEN-1:0]   pcIn,
  input  logic [IRQ_N-2:0]  irqLines,
  input  logic [XLEN-1:0]   regWrData,
  output logic              intrReady,
  output logic              trapsEnabled,
  output logic              countMatch,
  output logic              redirect,
  output logic [XLEN-1:0]   trapTarget,
  output logic [XLEN-1:0]   epcOut,
  output logic [XLEN-1:0]   causeOut,
  output logic [XLEN-1:0]   statusOut
);
  localparam int TIMER_BIT = IRQ_N - 1;

  logic              etQ, supQ, psupQ;
  logic [IRQ_N-1:0]  maskQ;
  logic [IRQ_N-1:0]  pendQ;
  logic [CODE_W-1:0] codeQ;
  logic [XLEN-1:0]   countQ, compareQ, epcQ, vectorQ;
  logic              redirectQ;

  // status register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      etQ   <= 1'b0;
      supQ  <= 1'b1;
      psupQ <= 1'b0;
      maskQ <= '0;
    end else if (str.takeTrap) begin
      etQ   <= 1'b0;
      supQ  <= 1'b1;
      psupQ <= supQ;
    end else if (str.wrStatus) begin
      etQ   <= regWrData[ST_ET];
      supQ  <= regWrData[ST_SUP];
      psupQ <= regWrData[ST_PSUP];
      maskQ <= regWrData[ST_MASK +: IRQ_N];
    end
  end

  // counter and compare
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ   <= '0;
      compareQ <= '0;
    end else begin
      if (str.wrCount)       countQ <= regWrData;
      else if (str.countInc) countQ <= countQ + 1'b1;
      if (str.wrCompare)     compareQ <= regWrData;
    end
  end

  // cause: code field and pending flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ <= '0;
      pendQ <= '0;
    end else begin
      if (str.takeTrap)     codeQ <= str.trapCode;
      else if (str.wrCause) codeQ <= regWrData[CODE_W-1:0];
      for (int i = 0; i < IRQ_N; i++) begin
        if (i == TIMER_BIT) begin
          if (str.wrCompare)     pendQ[i] <= 1'b0;
          else if (str.timerSet) pendQ[i] <= 1'b1;
          else if (str.wrCause)  pendQ[i] <= regWrData[CA_PEND + i];
        end else begin
          pendQ[i] <= irqLines[i];
        end
      end
    end
  end

  // exception PC, vector, redirect
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      epcQ      <= '0;
      vectorQ   <= '0;
      redirectQ <= 1'b0;
    end else begin
      redirectQ <= str.takeTrap;
      if (str.takeTrap) epcQ    <= pcIn;
      if (str.wrVector) vectorQ <= regWrData;
    end
  end

  always_comb begin
    intrReady    = |(pendQ & maskQ);
    trapsEnabled = etQ;
    countMatch   = (countQ == compareQ);
    redirect     = redirectQ;
    trapTarget   = vectorQ;
    epcOut       = epcQ;
    causeOut     = '0;
    causeOut[CODE_W-1:0]          = codeQ;
    causeOut[CA_PEND +: IRQ_N]    = pendQ;
    statusOut    = '0;
    statusOut[ST_ET]              = etQ;
    statusOut[ST_SUP]             = supQ;
    statusOut[ST_PSUP]            = psupQ;
    statusOut[ST_MASK +: IRQ_N]   = maskQ;
  end

  // R2: completed slot advances count by one
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (str.countInc && !str.wrCount) |=> countQ == XLEN'($past(countQ) + 1'b1))
    else $error("count step");

  // R4: compare write leaves timer flag clear
  a_r4_compare_clears: assert property (@(posedge clk) disable iff (!rstN)
    str.wrCompare |=> !pendQ[TIMER_BIT])
    else $error("timer flag after compare write");

  // R10: status update on trap
  a_r10_trap_status: assert property (@(posedge clk) disable iff (!rstN)
    str.takeTrap |=> (!etQ && supQ && psupQ == $past(supQ) && $stable(maskQ)))
    else $error("status on trap");

  // R11: trap keeps the timer flag
  a_r11_keep_timer: assert property (@(posedge clk) disable iff (!rstN)
    (str.takeTrap && !str.wrCompare && !str.wrCause) |=> $stable(pendQ[TIMER_BIT]))
    else $error("timer flag lost on trap");

  // R12: saved PC and redirect pulse
  a_r12_epc_redirect: assert property (@(posedge clk) disable iff (!rstN)
    str.takeTrap |=> (epcQ == $past(pcIn) && redirectQ))
    else $error("epc or redirect");

endmodule

// File: rtl/trap_irq_unit.sv
module trap_irq_unit
  import tcu_pkg::*;
#(
  parameter int                XLEN     = 32,
  parameter logic [CODE_W-1:0] INT_CODE = 8'd6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotValid,
  input  logic [XLEN-1:0]   pcIn,
  input  logic              excReq,
  input  logic [CODE_W-1:0] excCode,
  input  logic [IRQ_N-2:0]  irqLines,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [XLEN-1:0]   regWrData,
  output logic              redirect,
  output logic [XLEN-1:0]   trapTarget,
  output logic [XLEN-1:0]   epcOut,
  output logic [XLEN-1:0]   causeOut,
  output logic [XLEN-1:0]   statusOut
);
  tcuStrobes_t str;
  logic intrReady, trapsEnabled, countMatch;

  tcu_ctrl #(.INT_CODE(INT_CODE)) uCtrl (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .excReq(excReq),
    .excCode(excCode), .regWrEn(regWrEn), .regAddr(regAddr),
    .intrReady(intrReady), .trapsEnabled(trapsEnabled),
    .countMatch(countMatch), .str(str)
  );

  tcu_dp #(.XLEN(XLEN)) uDp (
    .clk(clk), .rstN(rstN), .str(str), .pcIn(pcIn), .irqLines(irqLines),
    .regWrData(regWrData), .intrReady(intrReady),
    .trapsEnabled(trapsEnabled), .countMatch(countMatch),
    .redirect(redirect), .trapTarget(trapTarget), .epcOut(epcOut),
    .causeOut(causeOut), .statusOut(statusOut)
  );

  // R9: interrupt beats a same-slot exception
  a_r9_intr_first: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid && excReq && intrReady && trapsEnabled)
      |=> causeOut[CODE_W-1:0] == INT_CODE)
    else $error("exception won over interrupt");

endmodule

// File: tb/tb_trap_irq_unit.sv
module tb_trap_irq_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        slotValid = 1'b0;
  logic [31:0] pcIn = '0;
  logic        excReq = 1'b0;
  logic [7:0]  excCode = '0;
  logic [6:0]  irqLines = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic        redirect;
  logic [31:0] trapTarget, epcOut, causeOut, statusOut;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  trap_irq_unit dut (
    .clk(clk), .rstN(rstN), .slotValid(slotValid), .pcIn(pcIn),
    .excReq(excReq), .excCode(excCode), .irqLines(irqLines),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .redirect(redirect), .trapTarget(trapTarget), .epcOut(epcOut),
    .causeOut(causeOut), .statusOut(statusOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic slot(input logic [31:0] pc, input logic exc, input logic [7:0] code);
    slotValid = 1'b1; pcIn = pc; excReq = exc; excCode = code;
    step();
    slotValid = 1'b0; excReq = 1'b0;
  endtask

  // count readback through cause bit 15 is indirect; count is tracked via timer
  task automatic test_reset();
    chk("R1 status", statusOut, 32'h2);
    chk("R1 cause", causeOut, 32'h0);
    chk("R1 epc", epcOut, 32'h0);
    chk("R1 vector", trapTarget, 32'h0);
    chk("R1 redirect", {31'b0, redirect}, 32'h0);
  endtask

  task automatic test_count_timer();
    // count 0 -> 3 through three slots, then an idle cycle
    for (int i = 0; i < 3; i++) slot(32'h10 + 4*i, 1'b0, 8'h0);
    step();
    wr(3'd2, 32'd5);                       // compare = 5, count stays 3
    slot(32'h20, 1'b0, 8'h0);              // 3 -> 4
    chk("R2 no early match", causeOut & 32'h8000, 32'h0);
    slot(32'h24, 1'b0, 8'h0);              // 4 -> 5
    chk("R3 before match", causeOut & 32'h8000, 32'h0);
    slot(32'h28, 1'b0, 8'h0);              // count was 5: match, 5 -> 6
    chk("R3 timer set", causeOut & 32'h8000, 32'h8000);
    wr(3'd2, 32'd8);
    chk("R4 compare write clears", causeOut & 32'h8000, 32'h0);
    slot(32'h2c, 1'b0, 8'h0);              // 6 -> 7
    slot(32'h30, 1'b0, 8'h0);              // 7 -> 8
    chk("R4 old compare unused", causeOut & 32'h8000, 32'h0);
    slot(32'h34, 1'b0, 8'h0);              // count was 8: match
    chk("R4 new compare loaded", causeOut & 32'h8000, 32'h8000);
    wr(3'd2, 32'd1000);
    // R2: write count then one slot brings it to compare match
    wr(3'd1, 32'd999);
    slot(32'h38, 1'b0, 8'h0);              // 999 -> 1000
    chk("R2 count write loads", causeOut & 32'h8000, 32'h0);
    slot(32'h3c, 1'b0, 8'h0);              // count was 1000: match
    chk("R2 count after write", causeOut & 32'h8000, 32'h8000);
    wr(3'd2, 32'd5000);
  endtask

  task automatic test_lines();
    irqLines = 7'h05;
    step();
    chk("R5 lines sampled", causeOut, 32'h0000_0500);
    wr(3'd3, 32'hFFFF_7F00);               // software cannot touch lines, upper
    chk("R5 cause write ignored on lines", causeOut, 32'h0000_0500);
    irqLines = 7'h10;
    step();
    chk("R5 lines follow", causeOut, 32'h0000_1000);
    irqLines = 7'h00;
    step();
  endtask

  task automatic test_masked();
    irqLines = 7'h04;                      // line 2 -> cause bit 10
    wr(3'd0, 32'h3);                       // ET, S, mask 0
    slot(32'h50, 1'b0, 8'h0);
    chk("R7 masked no redirect", {31'b0, redirect}, 32'h0);
    wr(3'd0, 32'h402);                     // mask bit 2, ET clear
    slot(32'h54, 1'b0, 8'h0);
    chk("R7 disabled no redirect", {31'b0, redirect}, 32'h0);
    chk("R7 status kept", statusOut, 32'h402);
  endtask

  task automatic test_interrupt();
    wr(3'd4, 32'h100);
    wr(3'd0, 32'h403);
    slot(32'h40, 1'b0, 8'h0);
    chk("R12 redirect", {31'b0, redirect}, 32'h1);
    chk("R12 target", trapTarget, 32'h100);
    chk("R12 epc", epcOut, 32'h40);
    chk("R6 cause code", causeOut, 32'h0406);
    chk("R10 status S=1", statusOut, 32'h406);
    step();
    chk("R12 redirect one cycle", {31'b0, redirect}, 32'h0);
    wr(3'd0, 32'h401);                     // ET=1, S=0
    slot(32'h44, 1'b0, 8'h0);
    chk("R10 status S=0", statusOut, 32'h402);
    chk("R12 epc second", epcOut, 32'h44);
  endtask

  task automatic test_priority_exc();
    wr(3'd0, 32'h403);
    slot(32'h48, 1'b1, 8'h03);
    chk("R9 interrupt wins", causeOut & 32'hFF, 32'h06);
    chk("R9 epc", epcOut, 32'h48);
    irqLines = 7'h00;
    wr(3'd0, 32'h3);
    wr(3'd3, 32'h8000);                    // timer flag set by software, code 0
    chk("R11 setup", causeOut, 32'h8000);
    slot(32'h80, 1'b1, 8'h0B);
    chk("R8 exception code", causeOut & 32'hFF, 32'h0B);
    chk("R11 pending kept", causeOut, 32'h800B);
    chk("R8 epc", epcOut, 32'h80);
    chk("R10 status after exc", statusOut, 32'h6);
    chk("R8 redirect", {31'b0, redirect}, 32'h1);
    slot(32'h84, 1'b1, 8'h0C);             // ET now clear: exception still traps
    chk("R8 exc with ET clear", causeOut, 32'h800C);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    test_reset();
    rstN = 1'b1;
    step();
    test_reset();
    test_count_timer();
    test_lines();
    test_masked();
    test_interrupt();
    test_priority_exc();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule